// File: doc/BRIEF.md
# Super I/O Configuration Port Controller

This block is the configuration front end of a legacy Super I/O device. Software reaches it over a byte-wide I/O bus with a 16-bit address, a write strobe, a read strobe and separate write and read data. Two byte addresses form an index/data pair. A byte written to the index port chooses a configuration register. The next access to the data port reads or writes that register.

Configuration mode stays closed until a fixed four-byte key arrives on the index port. Once open, software can select a logical device, read the chip identification bytes, and program the general-purpose I/O device. The I/O device settings are its 16-bit I/O base address, its per-group plain-I/O enables and its per-group output enables. These values leave the block as ports that feed the GPIO bank directly. A write of a specific value to a global control register closes configuration mode again. The programmed settings are kept and stay in force on the output ports.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the block is locked (`cfg_mode`=0), the index and logical-device registers are 0x00, all GPIO configuration outputs are zero, and `io_rdata` is 0xFF.
- R2: Writing 0x87, 0x01, 0x55, 0x55 in that order to the index port (0x002E) while locked sets `cfg_mode` after the edge that takes the final byte. Writes to any other address between key bytes neither advance nor break the match.
- R3: A wrong byte on the index port during key entry restarts matching. A wrong byte equal to 0x87 counts as the first key byte of a new attempt.
- R4: While locked, data-port (0x002F) writes change no register, and reads of either port return 0xFF.
- R5: While unlocked, an index-port write loads the index register, and an index-port read returns it.
- R6: Index 0x07 is the readable and writable logical-device number register. Device 0x07 is the GPIO device.
- R7: Index 0x20 reads the chip ID high byte and 0x21 the low byte (parameter, default 0x8728). Index 0x22 reads the revision in bits [3:0] with bits [7:4] zero. All three ignore writes.
- R8: With device 0x07 selected, index 0x62 holds bits [15:8] and 0x63 bits [7:0] of `gpio_io_base`. Both are readable and writable.
- R9: With device 0x07 selected, index 0xC0+g (g < N_SIMPLE) is the plain-I/O enable byte of group g, driving `gpio_simple_en[8g+7:8g]`. Index 0xC8+g (g < N_OE) is the output-enable byte of group g, driving `gpio_out_en[8g+7:8g]`. Indexes outside these ranges read 0x00.
- R10: With any other device selected, the GPIO indexes read 0x00 and ignore writes. The global registers at 0x07 and 0x20 to 0x22 remain reachable.
- R11: Writing 0x02 to index 0x02 while unlocked clears `cfg_mode` and the index register and keeps all GPIO settings. Any other value written there has no effect. A new full key is then needed.
- R12: `io_rdata` updates on the clock edge that samples `io_rd` and holds its value while `io_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe, one cycle per byte |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| cfg_mode | output | 1 | High while configuration mode is open |
| gpio_io_base | output | 16 | GPIO I/O base address |
| gpio_simple_en | output | N_SIMPLE*8 | Plain-I/O enables, one byte per group |
| gpio_out_en | output | N_OE*8 | Output enables, one byte per group |

## Verification
The bench targets the key matcher's restart rule. It sends a repeated 0x87 and a key broken at its third byte. A matcher that drops to idle on every mismatch would stay locked after 0x87, 0x87, 0x01, 0x55, 0x55. A matcher that never restarts would open on a broken key.

The bench also relocks with a near-miss value and then the real one. It then checks that a lone 0x55 cannot reopen the block and that the GPIO outputs survived the relock. A design that decoded the GPIO indexes without looking at the selected device would let a write under another device corrupt the base address. The bench also covers two further faults: the last plain-I/O group index aliasing into the output-enable range, and read data that drifts while no read is in progress.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    // Unlock key, written to the index port in this order
    localparam logic [7:0] KEY_FIRST = 8'h87;

    function automatic logic [7:0] key_at(input logic [1:0] pos);
        case (pos)
            2'd0:    key_at = 8'h87;
            2'd1:    key_at = 8'h01;
            default: key_at = 8'h55;
        endcase
    endfunction

    // Global register indexes
    localparam logic [7:0] IDX_CTRL    = 8'h02;
    localparam logic [7:0] CTRL_RELOCK = 8'h02;
    localparam logic [7:0] IDX_DEVSEL  = 8'h07;
    localparam logic [7:0] IDX_ID_HI   = 8'h20;
    localparam logic [7:0] IDX_ID_LO   = 8'h21;
    localparam logic [7:0] IDX_REV     = 8'h22;

    // GPIO device register indexes
    localparam logic [7:0] IDX_BASE_HI = 8'h62;
    localparam logic [7:0] IDX_BASE_LO = 8'h63;
    localparam logic [7:0] IDX_SIMPLE0 = 8'hC0;
    localparam logic [7:0] IDX_OE0     = 8'hC8;

    localparam logic [7:0] RD_NONE     = 8'hFF;

    typedef enum logic [2:0] {
        KEY_W0   = 3'd0,
        KEY_W1   = 3'd1,
        KEY_W2   = 3'd2,
        KEY_W3   = 3'd3,
        KEY_OPEN = 3'd4
    } key_state_e;

    typedef struct packed {
        logic idx_wr;
        logic dat_wr;
        logic idx_rd;
        logic dat_rd;
    } port_op_t;

    function automatic port_op_t decode_op(
        input logic [15:0] addr,
        input logic        wr,
        input logic        rd,
        input logic [15:0] idx_addr,
        input logic [15:0] dat_addr
    );
        port_op_t op;
        op.idx_wr = wr && (addr == idx_addr);
        op.dat_wr = wr && (addr == dat_addr);
        op.idx_rd = rd && (addr == idx_addr);
        op.dat_rd = rd && (addr == dat_addr);
        return op;
    endfunction

endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    input  logic       relock,
    output logic       unlocked_o
);

    key_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (relock) begin
            st_d = KEY_W0;
        end else if (st_q != KEY_OPEN && key_wr) begin
            if (key_byte == key_at(st_q[1:0]))
                st_d = key_state_e'(st_q + 3'd1);
            else if (key_byte == KEY_FIRST)
                st_d = KEY_W1;
            else
                st_d = KEY_W0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= KEY_W0;
        else     st_q <= st_d;
    end

    assign unlocked_o = (st_q == KEY_OPEN);

    // R2: opening only follows the last key byte
    p_open_on_last_key_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked_o) |-> $past(key_wr && key_byte == 8'h55));

    // R3: a 0x87 during key entry always leaves the matcher one byte in
    p_first_key_restart_r3: assert property (@(posedge clk) disable iff (rst)
        (key_wr && !unlocked_o && !relock && key_byte == 8'h87) |=> (st_q == KEY_W1));

    // R11: relock closes configuration mode
    p_relock_closes_r11: assert property (@(posedge clk) disable iff (rst)
        relock |=> !unlocked_o);

endmodule

// File: rtl/sio_gpio_dev_regs.sv
module sio_gpio_dev_regs
    import sio_cfg_pkg::*;
#(
    parameter int N_SIMPLE = 5,
    parameter int N_OE     = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [7:0]            idx_i,
    input  logic [7:0]            wdata_i,
    output logic [7:0]            rdata_o,
    output logic [15:0]           base_o,
    output logic [N_SIMPLE*8-1:0] simple_o,
    output logic [N_OE*8-1:0]     oe_o
);

    logic [15:0]                base_q;
    logic [N_SIMPLE-1:0][7:0]   simple_q;
    logic [N_OE-1:0][7:0]       oe_q;
    logic [N_SIMPLE-1:0]        simple_hit;
    logic [N_OE-1:0]            oe_hit;

    genvar g;
    generate
        for (g = 0; g < N_SIMPLE; g++) begin : g_simple_dec
            assign simple_hit[g] = (idx_i == IDX_SIMPLE0 + 8'(g));
        end
        for (g = 0; g < N_OE; g++) begin : g_oe_dec
            assign oe_hit[g] = (idx_i == IDX_OE0 + 8'(g));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            simple_q <= '0;
            oe_q     <= '0;
        end else if (wr_en) begin
            if (idx_i == IDX_BASE_HI) base_q[15:8] <= wdata_i;
            if (idx_i == IDX_BASE_LO) base_q[7:0]  <= wdata_i;
            for (int i = 0; i < N_SIMPLE; i++)
                if (simple_hit[i]) simple_q[i] <= wdata_i;
            for (int i = 0; i < N_OE; i++)
                if (oe_hit[i]) oe_q[i] <= wdata_i;
        end
    end

    always_comb begin
        rdata_o = 8'h00;
        if (idx_i == IDX_BASE_HI) rdata_o = base_q[15:8];
        if (idx_i == IDX_BASE_LO) rdata_o = base_q[7:0];
        for (int i = 0; i < N_SIMPLE; i++)
            if (simple_hit[i]) rdata_o = simple_q[i];
        for (int i = 0; i < N_OE; i++)
            if (oe_hit[i]) rdata_o = oe_q[i];
    end

    assign base_o   = base_q;
    assign simple_o = simple_q;
    assign oe_o     = oe_q;

    // R9: the register file accepts no change without a write enable
    p_regs_need_write_r9: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(base_o) && $stable(simple_o) && $stable(oe_o)));

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter logic [15:0] IDX_ADDR = 16'h002E,
    parameter logic [15:0] DAT_ADDR = 16'h002F,
    parameter logic [15:0] CHIP_ID  = 16'h8728,
    parameter logic [3:0]  CHIP_REV = 4'h3,
    parameter logic [7:0]  GPIO_DEV = 8'h07,
    parameter int          N_SIMPLE = 5,   // at most 8 groups
    parameter int          N_OE     = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [15:0]           io_addr,
    input  logic                  io_wr,
    input  logic                  io_rd,
    input  logic [7:0]            io_wdata,
    output logic [7:0]            io_rdata,
    output logic                  cfg_mode,
    output logic [15:0]           gpio_io_base,
    output logic [N_SIMPLE*8-1:0] gpio_simple_en,
    output logic [N_OE*8-1:0]     gpio_out_en
);

    port_op_t   op;
    logic       unlocked;
    logic       cfg_wr;
    logic       relock;
    logic       gpio_sel;
    logic [7:0] index_q;
    logic [7:0] dev_q;
    logic [7:0] gpio_rd;
    logic [7:0] cfg_rd;
    logic [7:0] rdata_q;

    assign op       = decode_op(io_addr, io_wr, io_rd, IDX_ADDR, DAT_ADDR);
    assign cfg_wr   = op.dat_wr && unlocked;
    assign relock   = cfg_wr && (index_q == IDX_CTRL) && (io_wdata == CTRL_RELOCK);
    assign gpio_sel = (dev_q == GPIO_DEV);

    sio_key_fsm u_key (
        .clk        (clk),
        .rst        (rst),
        .key_wr     (op.idx_wr && !unlocked),
        .key_byte   (io_wdata),
        .relock     (relock),
        .unlocked_o (unlocked)
    );

    always_ff @(posedge clk) begin
        if (rst || relock)
            index_q <= 8'h00;
        else if (op.idx_wr && unlocked)
            index_q <= io_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)
            dev_q <= 8'h00;
        else if (cfg_wr && index_q == IDX_DEVSEL)
            dev_q <= io_wdata;
    end

    sio_gpio_dev_regs #(
        .N_SIMPLE (N_SIMPLE),
        .N_OE     (N_OE)
    ) u_gpio (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr && gpio_sel),
        .idx_i    (index_q),
        .wdata_i  (io_wdata),
        .rdata_o  (gpio_rd),
        .base_o   (gpio_io_base),
        .simple_o (gpio_simple_en),
        .oe_o     (gpio_out_en)
    );

    always_comb begin
        case (index_q)
            IDX_DEVSEL: cfg_rd = dev_q;
            IDX_ID_HI:  cfg_rd = CHIP_ID[15:8];
            IDX_ID_LO:  cfg_rd = CHIP_ID[7:0];
            IDX_REV:    cfg_rd = {4'h0, CHIP_REV};
            default:    cfg_rd = gpio_sel ? gpio_rd : 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= RD_NONE;
        else if (io_rd) begin
            if (op.idx_rd && unlocked)      rdata_q <= index_q;
            else if (op.dat_rd && unlocked) rdata_q <= cfg_rd;
            else                            rdata_q <= RD_NONE;
        end
    end

    assign io_rdata = rdata_q;
    assign cfg_mode = unlocked;

    // R4: nothing configurable moves while locked
    p_locked_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        !cfg_mode |=> ($stable(dev_q) && $stable(gpio_io_base) &&
                       $stable(gpio_simple_en) && $stable(gpio_out_en)));

    // R4: locked reads see the idle pattern
    p_locked_read_ff_r4: assert property (@(posedge clk) disable iff (rst)
        (io_rd && !cfg_mode) |=> (io_rdata == 8'hFF));

    // R10: GPIO settings hold while another device is selected
    p_other_dev_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        (dev_q != GPIO_DEV) |=> ($stable(gpio_io_base) &&
                                 $stable(gpio_simple_en) && $stable(gpio_out_en)));

    // R11: the relock write closes the block
    p_ctrl_relock_r11: assert property (@(posedge clk) disable iff (rst)
        (op.dat_wr && cfg_mode && index_q == 8'h02 && io_wdata == 8'h02) |=> !cfg_mode);

    // R12: read data holds between reads
    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !io_rd |=> $stable(io_rdata));

endmodule

// File: tb/sio_cfg_port_test.sv
module sio_cfg_port_test;

    localparam logic [15:0] IA = 16'h002E;
    localparam logic [15:0] DA = 16'h002F;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] io_addr;
    logic        io_wr;
    logic        io_rd;
    logic [7:0]  io_wdata;
    logic [7:0]  io_rdata;
    logic        cfg_mode;
    logic [15:0] gpio_io_base;
    logic [39:0] gpio_simple_en;
    logic [63:0] gpio_out_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sio_cfg_port uut (
        .clk            (clk),
        .rst            (rst),
        .io_addr        (io_addr),
        .io_wr          (io_wr),
        .io_rd          (io_rd),
        .io_wdata       (io_wdata),
        .io_rdata       (io_rdata),
        .cfg_mode       (cfg_mode),
        .gpio_io_base   (gpio_io_base),
        .gpio_simple_en (gpio_simple_en),
        .gpio_out_en    (gpio_out_en)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        d = io_rdata;
    endtask

    task automatic cfg_wr(input logic [7:0] idx, input logic [7:0] d);
        bus_wr(IA, idx);
        bus_wr(DA, d);
    endtask

    task automatic cfg_rd(input logic [7:0] idx, output logic [7:0] d);
        bus_wr(IA, idx);
        bus_rd(DA, d);
    endtask

    task automatic send_key();
        bus_wr(IA, 8'h87); bus_wr(IA, 8'h01); bus_wr(IA, 8'h55); bus_wr(IA, 8'h55);
    endtask

    task automatic t_reset();
        chk("R1", "cfg_mode", cfg_mode, 0);
        chk("R1", "rdata", io_rdata, 8'hFF);
        chk("R1", "base", gpio_io_base, 0);
        chk("R1", "simple", gpio_simple_en, 0);
        chk("R1", "oe", gpio_out_en, 0);
    endtask

    task automatic t_locked();
        logic [7:0] v;
        bus_wr(DA, 8'h07);
        bus_rd(DA, v);  chk("R4", "locked data read", v, 8'hFF);
        bus_rd(IA, v);  chk("R4", "locked index read", v, 8'hFF);
        chk("R4", "still locked", cfg_mode, 0);
    endtask

    task automatic t_unlock();
        logic [7:0] v;
        bus_wr(IA, 8'h87); bus_wr(IA, 8'h01);
        bus_wr(16'h0080, 8'h33); bus_wr(DA, 8'h12);
        bus_wr(IA, 8'h55);
        chk("R2", "not open before last byte", cfg_mode, 0);
        bus_wr(IA, 8'h55);
        chk("R2", "open after key", cfg_mode, 1);
        cfg_rd(8'h07, v); chk("R4", "locked device write ignored", v, 8'h00);
        bus_rd(IA, v);    chk("R5", "index readback", v, 8'h07);
    endtask

    task automatic t_ids();
        logic [7:0] v;
        cfg_rd(8'h20, v); chk("R7", "id hi", v, 8'h87);
        cfg_rd(8'h21, v); chk("R7", "id lo", v, 8'h28);
        cfg_rd(8'h22, v); chk("R7", "rev", v, 8'h03);
        cfg_wr(8'h20, 8'h00);
        cfg_rd(8'h20, v); chk("R7", "id hi after write", v, 8'h87);
    endtask

    task automatic t_devsel();
        logic [7:0] v;
        cfg_wr(8'h07, 8'h07);
        cfg_rd(8'h07, v); chk("R6", "device select", v, 8'h07);
    endtask

    task automatic t_base();
        logic [7:0] v;
        cfg_wr(8'h62, 8'h0A);
        cfg_wr(8'h63, 8'h40);
        chk("R8", "gpio_io_base", gpio_io_base, 16'h0A40);
        cfg_rd(8'h62, v); chk("R8", "base hi read", v, 8'h0A);
        cfg_rd(8'h63, v); chk("R8", "base lo read", v, 8'h40);
    endtask

    task automatic t_groups();
        logic [7:0] v;
        cfg_wr(8'hC2, 8'h55);
        cfg_wr(8'hC4, 8'h3C);
        cfg_wr(8'hCF, 8'hA5);
        cfg_wr(8'hC8, 8'h11);
        chk("R9", "simple group2", gpio_simple_en[23:16], 8'h55);
        chk("R9", "simple group4", gpio_simple_en[39:32], 8'h3C);
        chk("R9", "simple others", {gpio_simple_en[31:24], gpio_simple_en[15:0]}, 0);
        chk("R9", "oe group7", gpio_out_en[63:56], 8'hA5);
        chk("R9", "oe group0", gpio_out_en[7:0], 8'h11);
        cfg_rd(8'hCF, v); chk("R9", "oe group7 read", v, 8'hA5);
        cfg_wr(8'hC5, 8'hEE);
        cfg_rd(8'hC5, v); chk("R9", "unmapped simple index", v, 8'h00);
        chk("R9", "oe untouched by unmapped", gpio_out_en, 64'hA500_0000_0000_0011);
    endtask

    task automatic t_other_dev();
        logic [7:0] v;
        cfg_wr(8'h07, 8'h03);
        cfg_wr(8'h62, 8'hFF);
        cfg_wr(8'hC2, 8'h00);
        chk("R10", "base kept", gpio_io_base, 16'h0A40);
        chk("R10", "simple kept", gpio_simple_en[23:16], 8'h55);
        cfg_rd(8'h62, v); chk("R10", "gpio index reads zero", v, 8'h00);
        cfg_rd(8'h20, v); chk("R10", "global id still visible", v, 8'h87);
        cfg_wr(8'h07, 8'h07);
        cfg_rd(8'h62, v); chk("R10", "base back under gpio", v, 8'h0A);
    endtask

    task automatic t_latency();
        logic [7:0] v;
        bus_wr(IA, 8'h21);
        bus_rd(DA, v);  chk("R12", "read value", v, 8'h28);
        bus_wr(IA, 8'h20);
        @(negedge clk);
        chk("R12", "held without read", io_rdata, 8'h28);
    endtask

    task automatic t_relock();
        logic [7:0] v;
        cfg_wr(8'h02, 8'h01);
        chk("R11", "near-miss keeps open", cfg_mode, 1);
        cfg_wr(8'h02, 8'h02);
        chk("R11", "relocked", cfg_mode, 0);
        bus_rd(DA, v); chk("R11", "read after relock", v, 8'hFF);
        chk("R11", "base survives relock", gpio_io_base, 16'h0A40);
        bus_wr(IA, 8'h55);
        chk("R11", "lone byte cannot reopen", cfg_mode, 0);
        send_key();
        bus_rd(IA, v); chk("R11", "index cleared by relock", v, 8'h00);
        cfg_wr(8'h02, 8'h02);
    endtask

    task automatic t_bad_key();
        bus_wr(IA, 8'h87); bus_wr(IA, 8'h01); bus_wr(IA, 8'h54);
        bus_wr(IA, 8'h55); bus_wr(IA, 8'h55);
        chk("R3", "broken key stays locked", cfg_mode, 0);
        bus_wr(IA, 8'h87); bus_wr(IA, 8'h87); bus_wr(IA, 8'h01);
        bus_wr(IA, 8'h55); bus_wr(IA, 8'h55);
        chk("R3", "repeated first byte opens", cfg_mode, 1);
        cfg_wr(8'h02, 8'h02);
        bus_wr(IA, 8'h87); bus_wr(IA, 8'h01); bus_wr(IA, 8'h55);
        send_key();
        chk("R3", "restart from third byte opens", cfg_mode, 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        rst = 1'b1; io_addr = '0; io_wr = 1'b0; io_rd = 1'b0; io_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_locked();
        t_unlock();
        t_ids();
        t_devsel();
        t_base();
        t_groups();
        t_other_dev();
        t_latency();
        t_relock();
        t_bad_key();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule